// File: doc/BRIEF.md
# Synthesizer Divider Chain

This block is the digital divider section of a tuner frequency synthesizer. It produces two streams of comparison pulses for a phase detector. The reference stream comes from dividing a 75 kHz crystal clock. The variable stream comes from dividing one of two RF divider inputs. Everything runs in one system clock domain. Each divider input arrives as a one-cycle tick strobe rather than as a clock of its own.

A 16-bit divide word and two band bits set the variable ratio. The band bits choose the input and the division mode. In the high band the ratio is twice the word. In the fine low band it is the word itself. In the coarse low band it is the upper twelve bits of the word. A 4-bit reference code selects one of eight reference ratios, or selects one of two inhibit states. In both inhibit states both dividers stop and an inhibit flag is raised; one of the two states also signals that the crystal oscillator is halted.

Ratio changes are deferred to the end of the period in progress, so an output pulse train never contains a shortened period.

Top module: `synth_divider_chain`

## Requirements
- R1: In reset both pulse outputs, `inhibit` and `xtal_halt` are 0. The first counted tick after reset produces a pulse on that divider's output and starts a new period.
- R2: The reference divider emits one pulse per N `xtal_tick` strobes. N is chosen by `ref_code` (binary, bit 3 = MSB) as follows: 0–3 give 3; 4 gives 6; 5 gives 12; 6 and 7 give 24; 8–10 give 15; 11 gives 75; 12 gives 25; 13 gives 5.
- R3: `ref_code` = 15 sets `inhibit`=1 and `xtal_halt`=0 one clock after it is sampled. While the inhibit code is applied, neither output pulses and both dividers restart, so the first counted tick after release pulses.
- R4: `ref_code` = 14 behaves as R3, and in addition sets `xtal_halt`=1. `xtal_halt` is never 1 unless `inhibit` is 1.
- R5: With `hi_band`=1 the variable divider counts only `rfh_tick` and `rfl_tick` is ignored. The ratio is twice the divide word.
- R6: With `hi_band`=0 and `fine_step`=1 the variable divider counts only `rfl_tick` and `rfh_tick` is ignored. The ratio equals the divide word.
- R7: With `hi_band`=0 and `fine_step`=0 the variable divider counts `rfl_tick`. The ratio is `div_word[15:4]` and bits 3..0 have no effect.
- R8: A word value below the mode minimum is clamped to that minimum. In the modes of R5 and R6 the minimum is 272, applied before the doubling in R5. In the mode of R7 the minimum is 4.
- R9: A new divide word, band selection ratio or reference code is sampled only on the tick that ends a period, so the period in progress completes with its old ratio.
- R10: Each pulse is one clock wide. It appears in the clock after the edge that sampled the terminal tick, and never two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_word | input | 16 | Variable divide word, bit 15 = MSB |
| hi_band | input | 1 | 1: high-band input, doubled ratio |
| fine_step | input | 1 | Low-band mode when hi_band=0: 1 fine, 0 coarse |
| ref_code | input | 4 | Reference ratio / inhibit code |
| xtal_tick | input | 1 | One-cycle strobe per crystal period |
| rfh_tick | input | 1 | One-cycle strobe per high-band input period |
| rfl_tick | input | 1 | One-cycle strobe per low-band input period |
| ref_pulse | output | 1 | Reference comparison pulse |
| var_pulse | output | 1 | Variable comparison pulse |
| inhibit | output | 1 | Dividers stopped, pump held off |
| xtal_halt | output | 1 | Crystal oscillator stop requested |

## Verification
The bench feeds ticks on the selected input and on the unselected one in a random mix. A design that counted the wrong source, or both sources, would show a shifted pulse train. Words below the mode minimums and words with nonzero low nibbles in coarse mode are driven on purpose. Without the clamp the short period would show up at once, and using the low nibble would change the coarse ratio. Words and codes are also changed mid-period; a design that applied them at once would produce a runt period. Pulse trains are checked across inhibit release: a divider that kept its count through inhibit would delay its first pulse.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    localparam int DIV_W      = 16;
    localparam int COARSE_LSB = 4;
    localparam int CNT_W      = DIV_W + 1;
    localparam int REF_W      = 7;
    localparam int CODE_W     = 4;

    localparam logic [DIV_W-1:0]            WIDE_MIN   = 16'd272;
    localparam logic [DIV_W-COARSE_LSB-1:0] COARSE_MIN = 12'd4;

    typedef enum logic [1:0] {
        BAND_COARSE = 2'd0,
        BAND_FINE   = 2'd1,
        BAND_HIGH   = 2'd2
    } band_e;

    function automatic band_e band_decode(input logic hi, input logic fine);
        if (hi)
            return BAND_HIGH;
        else if (fine)
            return BAND_FINE;
        return BAND_COARSE;
    endfunction

    // Crystal ticks per reference pulse; inhibit codes return a harmless value.
    function automatic logic [REF_W-1:0] ref_ratio(input logic [CODE_W-1:0] code);
        logic [REF_W-1:0] r;
        case (code)
            4'd4:              r = 7'd6;
            4'd5:              r = 7'd12;
            4'd6, 4'd7:        r = 7'd24;
            4'd8, 4'd9, 4'd10: r = 7'd15;
            4'd11:             r = 7'd75;
            4'd12:             r = 7'd25;
            4'd13:             r = 7'd5;
            default:           r = 7'd3;
        endcase
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] var_ratio(input logic [DIV_W-1:0] word,
                                                   input band_e band);
        logic [CNT_W-1:0]            full;
        logic [DIV_W-COARSE_LSB-1:0] upper;
        logic [CNT_W-1:0]            coarse;
        full   = (word < WIDE_MIN) ? CNT_W'(WIDE_MIN) : CNT_W'(word);
        upper  = word[DIV_W-1:COARSE_LSB];
        coarse = (upper < COARSE_MIN) ? CNT_W'(COARSE_MIN) : CNT_W'(upper);
        case (band)
            BAND_HIGH: return full << 1;
            BAND_FINE: return full;
            default:   return coarse;
        endcase
    endfunction

endpackage

// File: rtl/band_select.sv
module band_select
    import synth_div_pkg::*;
(
    input  logic             hi_band,
    input  logic             fine_step,
    input  logic [DIV_W-1:0] div_word,
    input  logic             rfh_tick,
    input  logic             rfl_tick,
    output logic             sel_tick,
    output logic [CNT_W-1:0] sel_ratio
);
    band_e band;

    always_comb begin
        band      = band_decode(hi_band, fine_step);
        sel_tick  = (band == BAND_HIGH) ? rfh_tick : rfl_tick;
        sel_ratio = var_ratio(div_word, band);
    end
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         pulse
);
    logic [W-1:0] remain;

    // remain == 0 means the next tick ends a period; the new ratio is taken there.
    always_ff @(posedge clk) begin
        if (rst || hold) begin
            remain <= '0;
            pulse  <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (tick) begin
                if (remain == '0) begin
                    pulse  <= 1'b1;
                    remain <= ratio - 1'b1;
                end else begin
                    remain <= remain - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/synth_divider_chain.sv
module synth_divider_chain
    import synth_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div_word,
    input  logic              hi_band,
    input  logic              fine_step,
    input  logic [CODE_W-1:0] ref_code,
    input  logic              xtal_tick,
    input  logic              rfh_tick,
    input  logic              rfl_tick,
    output logic              ref_pulse,
    output logic              var_pulse,
    output logic              inhibit,
    output logic              xtal_halt
);
    logic             stop_now;
    logic             halt_now;
    logic             var_tick;
    logic [CNT_W-1:0] var_len;
    logic [REF_W-1:0] ref_len;

    always_comb begin
        stop_now = &ref_code[CODE_W-1:1];
        halt_now = stop_now & ~ref_code[0];
        ref_len  = ref_ratio(ref_code);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inhibit   <= 1'b0;
            xtal_halt <= 1'b0;
        end else begin
            inhibit   <= stop_now;
            xtal_halt <= halt_now;
        end
    end

    band_select u_band (
        .hi_band   (hi_band),
        .fine_step (fine_step),
        .div_word  (div_word),
        .rfh_tick  (rfh_tick),
        .rfl_tick  (rfl_tick),
        .sel_tick  (var_tick),
        .sel_ratio (var_len)
    );

    tick_divider #(.W(REF_W)) u_ref_div (
        .clk   (clk),
        .rst   (rst),
        .hold  (stop_now),
        .tick  (xtal_tick),
        .ratio (ref_len),
        .pulse (ref_pulse)
    );

    tick_divider #(.W(CNT_W)) u_var_div (
        .clk   (clk),
        .rst   (rst),
        .hold  (stop_now),
        .tick  (var_tick),
        .ratio (var_len),
        .pulse (var_pulse)
    );
endmodule

// File: rtl/synth_divider_chain_chk.sv
module synth_divider_chain_chk
    import synth_div_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DIV_W-1:0]  div_word,
    input logic              hi_band,
    input logic              fine_step,
    input logic [CODE_W-1:0] ref_code,
    input logic              xtal_tick,
    input logic              rfh_tick,
    input logic              rfl_tick,
    input logic              ref_pulse,
    input logic              var_pulse,
    input logic              inhibit,
    input logic              xtal_halt
);
    AST_REF_PULSE_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |-> $past(xtal_tick)) else $error("ref pulse without tick"); // R10
    AST_VAR_PULSE_FROM_SEL: assert property (@(posedge clk) disable iff (rst)
        var_pulse |-> $past(hi_band ? rfh_tick : rfl_tick)) else $error("var pulse from wrong input"); // R5
    AST_REF_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |=> !ref_pulse) else $error("ref pulse too wide"); // R10
    AST_VAR_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
        var_pulse |=> !var_pulse) else $error("var pulse too wide"); // R10
    AST_INHIBIT_SILENT: assert property (@(posedge clk) disable iff (rst)
        inhibit |-> (!ref_pulse && !var_pulse)) else $error("pulse while inhibited"); // R3
    AST_HALT_NEEDS_INHIBIT: assert property (@(posedge clk) disable iff (rst)
        xtal_halt |-> inhibit) else $error("halt without inhibit"); // R4
    AST_HALT_CODE: assert property (@(posedge clk) disable iff (rst)
        (ref_code == 4'd14) |=> (xtal_halt && inhibit)) else $error("halt code not honoured"); // R4
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!ref_pulse && !var_pulse && !inhibit && !xtal_halt)) else $error("outputs active after reset"); // R1
endmodule

bind synth_divider_chain synth_divider_chain_chk u_chk (.*);

// File: tb/tb_synth_divider_chain.sv
`timescale 1ns/1ps
module tb_synth_divider_chain;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] div_word;
    logic        hi_band, fine_step;
    logic [3:0]  ref_code;
    logic        xtal_tick, rfh_tick, rfl_tick;
    logic        ref_pulse, var_pulse, inhibit, xtal_halt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    synth_divider_chain dut (.*);

    // Expected-value model state, built from the requirements.
    int  ref_left, var_left;
    bit  exp_ref, exp_var;

    function automatic int ref_exp(input logic [3:0] c);
        case (c)
            4'd0, 4'd1, 4'd2, 4'd3: return 3;
            4'd4: return 6;
            4'd5: return 12;
            4'd6, 4'd7: return 24;
            4'd8, 4'd9, 4'd10: return 15;
            4'd11: return 75;
            4'd12: return 25;
            default: return 5;
        endcase
    endfunction

    function automatic int var_exp(input logic [15:0] w, input logic hi, input logic fine);
        int v;
        if (!hi && !fine) begin
            v = int'(w) >> 4;
            return (v < 4) ? 4 : v;
        end
        v = (int'(w) < 272) ? 272 : int'(w);
        return hi ? 2 * v : v;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, advance the model, compare at the next falling edge.
    task automatic step(input bit xt, input bit rh, input bit rl, inout int mism);
        bit stopped, sel;
        xtal_tick = xt; rfh_tick = rh; rfl_tick = rl;
        stopped = (ref_code[3:1] == 3'b111);
        sel = hi_band ? rh : rl;
        exp_ref = 1'b0; exp_var = 1'b0;
        if (stopped) begin
            ref_left = 0; var_left = 0;
        end else begin
            if (xt) begin
                if (ref_left == 0) begin exp_ref = 1'b1; ref_left = ref_exp(ref_code) - 1; end
                else ref_left--;
            end
            if (sel) begin
                if (var_left == 0) begin exp_var = 1'b1; var_left = var_exp(div_word, hi_band, fine_step) - 1; end
                else var_left--;
            end
        end
        @(negedge clk);
        if (ref_pulse !== exp_ref || var_pulse !== exp_var) mism++;
    endtask

    // Run one configuration from inhibit release; optionally switch word/code mid-run.
    task automatic scenario(input string req, input logic [3:0] code, input logic [15:0] word,
                            input bit hi, input bit fine, input int ncyc,
                            input int chg_at, input logic [3:0] code2, input logic [15:0] word2);
        int mism = 0;
        int npul = 0;
        ref_code = 4'd15;
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, mism);
        ref_code = code; div_word = word; hi_band = hi; fine_step = fine;
        for (int i = 0; i < ncyc; i++) begin
            int r;
            bit own;
            if (i == chg_at) begin ref_code = code2; div_word = word2; end
            r = int'($urandom % 4);
            own = (r >= 2);
            if (hi) step(1'($urandom % 2), own, r == 1, mism);
            else    step(1'($urandom % 2), r == 1, own, mism);
            if (exp_var) npul++;
        end
        check({req, " pulse train mismatches"}, mism, 0);
        if (npul < 2) begin
            errors++;
            $display("FAIL %s: only %0d variable pulses expected, scenario too short", req, npul);
        end
    endtask

    initial begin
        #(4ns * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int m;
        void'($urandom(32'd2024));
        rst = 1'b1; div_word = 16'd300; hi_band = 1'b0; fine_step = 1'b1;
        ref_code = 4'd0; xtal_tick = 1'b0; rfh_tick = 1'b0; rfl_tick = 1'b0;
        ref_left = 0; var_left = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ref_pulse in reset", int'(ref_pulse), 0);
        check("R1 var_pulse in reset", int'(var_pulse), 0);
        check("R1 inhibit in reset", int'(inhibit), 0);
        check("R1 xtal_halt in reset", int'(xtal_halt), 0);
        rst = 1'b0;
        // R1: first counted tick after reset pulses
        xtal_tick = 1'b1; rfl_tick = 1'b1;
        @(negedge clk);
        check("R1 first ref tick pulses", int'(ref_pulse), 1);
        check("R1 first var tick pulses", int'(var_pulse), 1);
        xtal_tick = 1'b0; rfl_tick = 1'b0;
        @(negedge clk);
        check("R10 ref pulse one clock wide", int'(ref_pulse), 0);
        check("R10 var pulse one clock wide", int'(var_pulse), 0);

        // R3 / R4: inhibit flags
        ref_code = 4'd15; @(negedge clk);
        check("R3 inhibit on code 15", int'(inhibit), 1);
        check("R3 no halt on code 15", int'(xtal_halt), 0);
        ref_code = 4'd14; @(negedge clk);
        check("R4 inhibit on code 14", int'(inhibit), 1);
        check("R4 halt on code 14", int'(xtal_halt), 1);
        m = 0;
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b1, m);
        check("R4 silent while halted", m, 0);
        ref_code = 4'd3; xtal_tick = 1'b0; rfh_tick = 1'b0; rfl_tick = 1'b0;
        @(negedge clk);
        check("R3 inhibit cleared", int'(inhibit), 0);
        check("R4 halt cleared", int'(xtal_halt), 0);

        // R2: every reference code, fine mode
        for (int c = 0; c < 14; c++)
            scenario("R2", 4'(c), 16'd272, 1'b0, 1'b1, 1300, -1, 4'd0, 16'd0);
        // R5 / R6 / R7 directed
        scenario("R5", 4'd0, 16'd290, 1'b1, 1'b0, 2600, -1, 4'd0, 16'd0);
        scenario("R6", 4'd11, 16'd333, 1'b0, 1'b1, 1600, -1, 4'd0, 16'd0);
        scenario("R7", 4'd4, 16'h00AF, 1'b0, 1'b0, 200, -1, 4'd0, 16'd0);
        scenario("R7", 4'd4, 16'h00A0, 1'b0, 1'b0, 200, -1, 4'd0, 16'd0);
        scenario("R7", 4'd13, 16'hFFF0, 1'b0, 1'b0, 8800, -1, 4'd0, 16'd0);
        // R8 clamps
        scenario("R8", 4'd0, 16'd5, 1'b1, 1'b0, 2500, -1, 4'd0, 16'd0);
        scenario("R8", 4'd0, 16'd0, 1'b0, 1'b1, 1300, -1, 4'd0, 16'd0);
        scenario("R8", 4'd0, 16'h002F, 1'b0, 1'b0, 120, -1, 4'd0, 16'd0);
        // R9 mid-period changes
        scenario("R9", 4'd11, 16'd400, 1'b0, 1'b1, 2600, 300, 4'd13, 16'd280);
        scenario("R9", 4'd13, 16'h0100, 1'b0, 1'b0, 300, 20, 4'd11, 16'h0060);
        // Random mix
        for (int k = 0; k < 10; k++) begin
            bit hi, fine;
            logic [15:0] w;
            hi = 1'($urandom % 2);
            fine = 1'($urandom % 2);
            w = (hi || fine) ? 16'(200 + $urandom % 200) : 16'((($urandom % 80) << 4) | ($urandom % 16));
            scenario(hi ? "R5 random" : (fine ? "R6 random" : "R7 random"),
                     4'($urandom % 14), w, hi, fine, 2600, 900, 4'($urandom % 14), w + 16'd7);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule